// File: doc/BRIEF.md
# Debug Control Register with Lock-Gated Save/Restore Fields

This block is the main 64-bit debug control register of a processor core. System software reads and writes it through a single register port. Some fields are held here: single-step enable, user comms-channel trap, kernel debug enable, monitor debug enable, step-operand enable, performance-unit access enable and the extended breakpoint enable. All of these reset to zero.

The other fields are windows onto a separate external debug status register pair, with a low word and a high word. These windows are live only while the OS-lock input is high. While locked, a read returns the matching bits of the external register and a write is forwarded through a masked side port, so only those bits change. While unlocked, the windows read as zero and writes to them are dropped.

Reserved bits and the read-as-zero range always read as zero and keep nothing that is written to them. A locked write that sets the receive-overrun or transmit-underrun flag while leaving the error flag clear is forwarded exactly as written.

Top module: `dbg_ctrl_reg`

## Requirements
- R1: After reset every read-back bit is 0 and the external write strobe is low.
- R2: A write updates the local fields one cycle later: bits 0, 12, 13, 15, 32, 34 and 50. Without a write they hold their value, whatever the state of the lock.
- R3: All bits that are neither local nor window bits read 0, whatever is written and whatever the external inputs hold. These include 18:16, 11:7, 5:1, 20, 25:24 and 28.
- R4: While the lock is 1, the window bits read the same-numbered external bits. The low-word window bits are 6, 14, 19, 21, 23:22, 26, 27, 29, 30 and 31. In the high word, bits 33 and 35 map to external high bits 1 and 3.
- R5: While the lock is 0, the window bits read 0 even when the external inputs are all ones.
- R6: A locked write raises the external write strobe for exactly the following cycle. In that cycle the low and high masks equal the window bit sets, and the data equals the written value restricted to those sets.
- R7: An unlocked write produces no external strobe and leaves the masks at 0, but still updates the local fields.
- R8: A locked write with bit 27 = 1 and bit 6 = 0, or with bit 26 = 1 and bit 6 = 0, forwards exactly those written values.
- R9: The external strobe is never high unless a locked write took place in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | OS-lock state; 1 opens the save/restore windows |
| sys_we_i | input | 1 | Register write enable |
| sys_wdata_i | input | 64 | Register write data |
| sys_rdata_o | output | 64 | Register read data (combinational) |
| ext_lo_i | input | 32 | Current value of external low status word |
| ext_hi_i | input | 32 | Current value of external high status word |
| ext_wr_o | output | 1 | External write strobe |
| ext_lo_mask_o | output | 32 | Per-bit write mask, low word |
| ext_lo_data_o | output | 32 | Write data, low word |
| ext_hi_mask_o | output | 32 | Per-bit write mask, high word |
| ext_hi_data_o | output | 32 | Write data, high word |

## Verification
The hardest situation to reach is a write that lands just as the lock changes. A locked write must reach the side port, and an unlocked write in the next cycle must leave no trace there, while the local fields must follow both writes. The stimulus reaches this by switching the lock between two back-to-back writes. It holds the external inputs at all ones, so that any window bit that leaks into the read-back or the strobe shows up at once. The overrun/underrun corner is driven with the error bit clear, and the forwarded data is compared bit for bit.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  localparam int REG_W  = 64;
  localparam int HALF_W = REG_W / 2;

  // local storage bit positions
  localparam int B_STEP     = 0;
  localparam int B_USRTRAP  = 12;
  localparam int B_KDBG     = 13;
  localparam int B_MONDBG   = 15;
  localparam int B_EXTBP    = 32;
  localparam int B_PMUEN    = 34;
  localparam int B_STEPOP   = 50;

  function automatic logic [REG_W-1:0] local_mask_f();
    logic [REG_W-1:0] m;
    m = '0;
    m[B_STEP] = 1'b1; m[B_USRTRAP] = 1'b1; m[B_KDBG] = 1'b1;
    m[B_MONDBG] = 1'b1; m[B_EXTBP] = 1'b1; m[B_PMUEN] = 1'b1;
    m[B_STEPOP] = 1'b1;
    return m;
  endfunction

  // window bits; position must match external register layout
  function automatic logic [REG_W-1:0] win_mask_f();
    logic [REG_W-1:0] m;
    m = '0;
    m[6] = 1'b1;      // error flag
    m[14] = 1'b1;     // halting enable
    m[19] = 1'b1;
    m[21] = 1'b1;     // access trap
    m[23:22] = 2'b11; // irq disable
    m[26] = 1'b1;     // tx underrun
    m[27] = 1'b1;     // rx overrun
    m[31:29] = 3'b111;
    m[33] = 1'b1;     // trace trap
    m[35] = 1'b1;     // ext halting bp enable
    return m;
  endfunction

  localparam logic [REG_W-1:0] LOCAL_MASK = local_mask_f();
  localparam logic [REG_W-1:0] WIN_MASK   = win_mask_f();
endpackage

// File: rtl/dbgc_local_store.sv
module dbgc_local_store #(
  parameter int W = 64,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= wdata_i & MASK;
  end
  assign q_o = q_q;
endmodule

// File: rtl/dbgc_ext_writer.sv
module dbgc_ext_writer #(
  parameter int W = 64,
  parameter logic [W-1:0] MASK = '0,
  parameter bit REG_OUT = 1'b1,
  localparam int HW = W / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          lock_i,
  input  logic [W-1:0]  wdata_i,
  output logic          wr_o,
  output logic [HW-1:0] lo_mask_o,
  output logic [HW-1:0] lo_data_o,
  output logic [HW-1:0] hi_mask_o,
  output logic [HW-1:0] hi_data_o
);
  logic         wr_d;
  logic [W-1:0] mask_d, data_d;

  assign wr_d   = we_i & lock_i;
  assign mask_d = wr_d ? MASK : '0;
  assign data_d = wr_d ? (wdata_i & MASK) : '0;

  generate
    if (REG_OUT) begin : g_reg
      logic         wr_q;
      logic [W-1:0] mask_q, data_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          wr_q   <= 1'b0;
          mask_q <= '0;
          data_q <= '0;
        end else begin
          wr_q   <= wr_d;
          mask_q <= mask_d;
          data_q <= data_d;
        end
      end
      assign wr_o      = wr_q;
      assign lo_mask_o = mask_q[HW-1:0];
      assign hi_mask_o = mask_q[W-1:HW];
      assign lo_data_o = data_q[HW-1:0];
      assign hi_data_o = data_q[W-1:HW];
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign wr_o      = wr_d;
      assign lo_mask_o = mask_d[HW-1:0];
      assign hi_mask_o = mask_d[W-1:HW];
      assign lo_data_o = data_d[HW-1:0];
      assign hi_data_o = data_d[W-1:HW];
    end
  endgenerate
endmodule

// File: rtl/dbgc_read_mux.sv
module dbgc_read_mux #(
  parameter int W = 64,
  parameter logic [W-1:0] LMASK = '0,
  parameter logic [W-1:0] WMASK = '0
) (
  input  logic         lock_i,
  input  logic [W-1:0] local_i,
  input  logic [W-1:0] ext_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] win;
  always_comb begin
    win     = lock_i ? (ext_i & WMASK) : '0;
    rdata_o = (local_i & LMASK) | win;
  end
endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbgc_pkg::*;
#(
  parameter bit EXT_REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              sys_we_i,
  input  logic [REG_W-1:0]  sys_wdata_i,
  output logic [REG_W-1:0]  sys_rdata_o,
  input  logic [HALF_W-1:0] ext_lo_i,
  input  logic [HALF_W-1:0] ext_hi_i,
  output logic              ext_wr_o,
  output logic [HALF_W-1:0] ext_lo_mask_o,
  output logic [HALF_W-1:0] ext_lo_data_o,
  output logic [HALF_W-1:0] ext_hi_mask_o,
  output logic [HALF_W-1:0] ext_hi_data_o
);
  logic [REG_W-1:0] local_q;

  dbgc_local_store #(.W(REG_W), .MASK(LOCAL_MASK)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(sys_we_i),
    .wdata_i(sys_wdata_i), .q_o(local_q)
  );

  dbgc_ext_writer #(.W(REG_W), .MASK(WIN_MASK), .REG_OUT(EXT_REG_OUT)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(sys_we_i), .lock_i(lock_i),
    .wdata_i(sys_wdata_i), .wr_o(ext_wr_o),
    .lo_mask_o(ext_lo_mask_o), .lo_data_o(ext_lo_data_o),
    .hi_mask_o(ext_hi_mask_o), .hi_data_o(ext_hi_data_o)
  );

  dbgc_read_mux #(.W(REG_W), .LMASK(LOCAL_MASK), .WMASK(WIN_MASK)) u_rd (
    .lock_i(lock_i), .local_i(local_q), .ext_i({ext_hi_i, ext_lo_i}),
    .rdata_o(sys_rdata_o)
  );
endmodule

// File: rtl/dbg_ctrl_reg_chk.sv
module dbg_ctrl_reg_chk
  import dbgc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lock_i,
  input logic              sys_we_i,
  input logic [REG_W-1:0]  sys_wdata_i,
  input logic [REG_W-1:0]  sys_rdata_o,
  input logic              ext_wr_o,
  input logic [HALF_W-1:0] ext_lo_mask_o,
  input logic [HALF_W-1:0] ext_lo_data_o,
  input logic [HALF_W-1:0] ext_hi_data_o
);
  localparam logic [REG_W-1:0] RSV = ~(LOCAL_MASK | WIN_MASK);

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rdata_o & RSV) == '0); // R3
  AST_UNLOCK_WIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |-> (sys_rdata_o & WIN_MASK) == '0); // R5
  AST_LOCK_WR_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_we_i && lock_i) |=> ext_wr_o); // R6
  AST_NO_STRAY_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sys_we_i && lock_i) |=> !ext_wr_o); // R9
  AST_FWD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_we_i && lock_i) |=> ({ext_hi_data_o, ext_lo_data_o} == ($past(sys_wdata_i) & WIN_MASK))); // R8
  AST_UNLOCK_NO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sys_we_i && lock_i) |=> ext_lo_mask_o == '0); // R7
  AST_LOCAL_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_we_i |=> (sys_rdata_o & LOCAL_MASK) == ($past(sys_wdata_i) & LOCAL_MASK)); // R2
  AST_LOCAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_we_i |=> $stable(sys_rdata_o & LOCAL_MASK)); // R2
endmodule

bind dbg_ctrl_reg dbg_ctrl_reg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(lock_i), .sys_we_i(sys_we_i),
  .sys_wdata_i(sys_wdata_i), .sys_rdata_o(sys_rdata_o), .ext_wr_o(ext_wr_o),
  .ext_lo_mask_o(ext_lo_mask_o), .ext_lo_data_o(ext_lo_data_o),
  .ext_hi_data_o(ext_hi_data_o)
);

// File: tb/sim_dbg_ctrl_reg.sv
`timescale 1ns/1ps
module sim_dbg_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock = 1'b0;
  logic        we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [31:0] ext_lo = '0, ext_hi = '0;
  logic        ext_wr;
  logic [31:0] lo_mask, lo_data, hi_mask, hi_data;

  always #4 clk = ~clk; // 125 MHz

  dbg_ctrl_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .lock_i(lock), .sys_we_i(we),
    .sys_wdata_i(wdata), .sys_rdata_o(rdata), .ext_lo_i(ext_lo),
    .ext_hi_i(ext_hi), .ext_wr_o(ext_wr), .ext_lo_mask_o(lo_mask),
    .ext_lo_data_o(lo_data), .ext_hi_mask_o(hi_mask), .ext_hi_data_o(hi_data)
  );

  // independent model constants from the requirements
  function automatic logic [63:0] bits_f(input int sel);
    logic [63:0] m = '0;
    if (sel == 0) begin
      foreach (m[i]) if (i == 0 || i == 12 || i == 13 || i == 15 || i == 32 || i == 34 || i == 50) m[i] = 1'b1;
    end else begin
      foreach (m[i]) if (i == 6 || i == 14 || i == 19 || i == 21 || i == 22 || i == 23 || i == 26 ||
                         i == 27 || (i >= 29 && i <= 31) || i == 33 || i == 35) m[i] = 1'b1;
    end
    return m;
  endfunction
  localparam logic [63:0] LM = bits_f(0);
  localparam logic [63:0] WM = bits_f(1);

  typedef struct {
    int          due;
    int          kind; // 0 rdata, 1 strobe, 2 lo data, 3 hi data, 4 lo mask, 5 hi mask
    logic [63:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  int cyc = 0, checks = 0, errors = 0;
  logic [63:0] model_local = '0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [63:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {63'd0, ext_wr};
        2: act = {32'd0, lo_data};
        3: act = {32'd0, hi_data};
        4: act = {32'd0, lo_mask};
        default: act = {32'd0, hi_mask};
      endcase
      checks++;
      if (act !== it.exp || it.due != cyc) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h cyc=%0d", it.req, it.kind, act, it.exp, cyc);
      end
    end
  end

  task automatic push(input int due, input int kind, input logic [63:0] e, input string r);
    item_t it;
    it.due = due; it.kind = kind; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  function automatic logic [63:0] exp_rd();
    return model_local | (lock ? ({ext_hi, ext_lo} & WM) : 64'd0);
  endfunction

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic do_read(input string r);
    push(cyc, 0, exp_rd(), r);
    step();
  endtask

  task automatic do_write(input logic [63:0] d, input string r);
    we = 1'b1; wdata = d;
    if (lock) begin
      push(cyc + 1, 1, 64'd1, r);
      push(cyc + 1, 2, {32'd0, d[31:0] & WM[31:0]}, r);
      push(cyc + 1, 3, {32'd0, d[63:32] & WM[63:32]}, r);
      push(cyc + 1, 4, {32'd0, WM[31:0]}, r);
      push(cyc + 1, 5, {32'd0, WM[63:32]}, r);
    end else begin
      push(cyc + 1, 1, 64'd0, r);
      push(cyc + 1, 4, 64'd0, r);
    end
    model_local = d & LM;
    step();
    we = 1'b0;
  endtask

  initial begin
    #1200;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R1 reset state
    push(cyc, 0, 64'd0, "R1"); push(cyc, 1, 64'd0, "R1");
    step();
    rst_n = 1'b1;
    step();
    ext_lo = '1; ext_hi = '1;
    do_read("R1");
    // R2/R7 unlocked write of all ones
    do_write('1, "R7");
    do_read("R2");
    do_read("R5");
    // R2 hold without write
    do_read("R2");
    // R4 locked reads
    lock = 1'b1;
    do_read("R4");
    ext_lo = 32'hA5A5_5A5A; ext_hi = 32'h0000_000A;
    do_read("R4");
    ext_hi = 32'h0000_0005; ext_lo = 32'h5A5A_A5A5;
    do_read("R4");
    // R6 locked write, checkerboard
    do_write(64'h5555_5555_5555_5555, "R6");
    do_read("R2");
    // R8 overrun with error clear, then underrun with error clear
    do_write(64'h0000_0000_0800_0000, "R8");
    do_write(64'h0000_0000_0400_0000, "R8");
    // R3 reserved bits, locked, externals all ones
    ext_lo = '1; ext_hi = '1;
    do_write(64'h0007_0000_1107_0FBE, "R3");
    do_read("R3");
    // lock switch between back-to-back writes (R9/R7)
    do_write(64'hFFFF_FFFF_0000_0000, "R9");
    lock = 1'b0;
    do_write(64'h0000_0000_FFFF_FFFF, "R7");
    push(cyc, 1, 64'd0, "R9");
    do_read("R5");
    step(); step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule